// File: doc/BRIEF.md
# Wrapping Down-Count Timer with Sticky Interrupt

This block is a general purpose 16-bit timer that counts down. A host programs it through a small write port and reads its state from dedicated outputs. The host can write a start value, turn counting on or off, turn interrupt signalling on or off, and clear a status flag by writing a one to it. While counting is on, the counter drops by one on each cycle in which the tick input is high. The tick is a single-cycle strobe that comes from a prescaler outside the block.

When the count is zero and a decrement is due, the counter does not reload. It rolls over to all-ones and carries on counting. The same event sets a status flag. That flag stays set until the host clears it. The interrupt output is high only while the flag is set and interrupts are enabled. A write to the start-value register puts the new value into the counter straight away, so the host can restart the countdown at any time.

Top module: `wrap_timer`

## Requirements
- R1: While reset is held, and after it is released before any write, the count reads FFFFh, the run enable and interrupt enable read 0, and the status flag and interrupt output are 0.
- R2: The count changes only on a cycle where the run enable is 1 and tick_i is 1. With tick_i low, or with the run enable off, the count holds.
- R3: A write to address 0 loads wr_data_i into the counter at that clock edge, whether the timer is running or stopped. If a tick occurs in the same cycle, the load takes priority.
- R4: When a decrement happens at count 0000h, the count becomes FFFFh and counting continues.
- R5: The decrement from 0000h to FFFFh sets the status flag at the same edge.
- R6: The status flag is sticky. A write to address 2 with data bit 0 equal to 0 leaves it set, and so do further ticks.
- R7: A write to address 2 with data bit 0 equal to 1 clears the status flag at that edge.
- R8: If a wrap and a clear write fall on the same edge, the flag ends up set.
- R9: irq_o is 1 exactly when the status flag is 1 and the interrupt enable is 1. A write to address 1 sets the run enable from data bit 0 and the interrupt enable from data bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | Single-cycle count strobe |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 2 | Write address: 0 start value, 1 control, 2 status |
| wr_data_i | input | 16 | Write data |
| count_o | output | 16 | Current count |
| run_o | output | 1 | Run enable |
| ien_o | output | 1 | Interrupt enable |
| status_o | output | 1 | Sticky wrap flag |
| irq_o | output | 1 | Interrupt output |

## Verification
The bench sets up the exact edge where the count is zero, a tick arrives and a clear write lands in the same cycle. A design that gave the clear priority would lose that wrap event and show the flag as 0. The bench also writes a start value together with a tick. A design that let the decrement win would read one less than the written value. It writes the control register on a tick-free cycle and then ticks with the timer stopped, which catches a counter that ignores the run enable. A write of zero to the status address is also covered, and a design that clears on any status write would drop the flag there.

// File: rtl/wrap_timer_pkg.sv
package wrap_timer_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_LOAD = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_IEN_BIT = 1;
  localparam int STAT_CLR_BIT = 0;
endpackage

// File: rtl/wt_rst_sync.sv
module wt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/wt_counter.sv
module wt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // A load wins over a decrement; zero minus one rolls to all-ones.
  always_comb begin
    cnt_en = load_i | step_i;
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '1;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign wrap_o  = step_i & ~load_i & (cnt_q == '0);
  assign count_o = cnt_q;
endmodule

// File: rtl/wt_status.sv
module wt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic ien_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, flag_d, flag_en;

  // Set has priority over a host clear landing on the same edge.
  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ien_i;
endmodule

// File: rtl/wrap_timer.sv
module wrap_timer
  import wrap_timer_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              run_o,
  output logic              ien_o,
  output logic              status_o,
  output logic              irq_o
);
  logic rst_sync_n;
  logic wr_load, wr_ctrl, wr_clr;
  logic run_q, run_d, ien_q, ien_d;
  logic step, wrap;

  wt_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .srst_n(rst_sync_n)
  );

  always_comb begin
    wr_load = wr_en_i & (wr_addr_i == A_LOAD);
    wr_ctrl = wr_en_i & (wr_addr_i == A_CTRL);
    wr_clr  = wr_en_i & (wr_addr_i == A_STAT) & wr_data_i[STAT_CLR_BIT];
    run_d   = wr_data_i[CTRL_RUN_BIT];
    ien_d   = wr_data_i[CTRL_IEN_BIT];
    step    = run_q & tick_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      run_q <= 1'b0;
      ien_q <= 1'b0;
    end else if (wr_ctrl) begin
      run_q <= run_d;
      ien_q <= ien_d;
    end
  end

  wt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_i    (wr_load),
    .load_val_i(wr_data_i),
    .step_i    (step),
    .count_o   (count_o),
    .wrap_o    (wrap)
  );

  wt_status u_stat (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (wrap),
    .clr_i (wr_clr),
    .ien_i (ien_q),
    .flag_o(status_o),
    .irq_o (irq_o)
  );

  assign run_o = run_q;
  assign ien_o = ien_q;
endmodule

// File: rtl/wrap_timer_chk.sv
module wrap_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              srst_n,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [CNT_W-1:0]  wr_data_i,
  input logic [CNT_W-1:0]  count_o,
  input logic              run_o,
  input logic              ien_o,
  input logic              status_o,
  input logic              irq_o
);
  logic ld, clr, stp;
  assign ld  = wr_en_i && (wr_addr_i == 2'd0);
  assign clr = wr_en_i && (wr_addr_i == 2'd2) && wr_data_i[0];
  assign stp = run_o && tick_i && !ld;

  p_hold_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (!ld && !stp) |=> $stable(count_o));

  p_dec_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (stp && count_o != '0) |=> (count_o == $past(count_o) - 1'b1));

  p_load_r3: assert property (@(posedge clk) disable iff (!srst_n)
    ld |=> (count_o == $past(wr_data_i)));

  p_wrap_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (stp && count_o == '0) |=> (count_o == '1));

  p_set_r5_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (stp && count_o == '0) |=> status_o);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (status_o && !clr) |=> status_o);

  p_clr_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (clr && !(stp && count_o == '0)) |=> !status_o);

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!srst_n)
    !ien_o |-> !irq_o);

  p_irq_on_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (status_o && ien_o) |-> irq_o);
endmodule

bind wrap_timer wrap_timer_chk #(.CNT_W(CNT_W), .ADDR_W(wrap_timer_pkg::ADDR_W)) u_chk (
  .clk      (clk),
  .srst_n   (rst_sync_n),
  .tick_i   (tick_i),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .count_o  (count_o),
  .run_o    (run_o),
  .ien_o    (ien_o),
  .status_o (status_o),
  .irq_o    (irq_o)
);

// File: tb/sim_wrap_timer.sv
module sim_wrap_timer;
  localparam int PERIOD = 10;
  localparam int NV = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] count_o;
  logic        run_o, ien_o, status_o, irq_o;
  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  wrap_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .count_o(count_o),
    .run_o(run_o), .ien_o(ien_o), .status_o(status_o), .irq_o(irq_o)
  );

  // {wr, addr, data, tick, exp_count, exp_status, exp_irq, req}
  localparam logic [41:0] VEC [NV] = '{
    {1'b1, 2'd1, 16'h0001, 1'b0, 16'hFFFF, 1'b0, 1'b0, 4'd2}, // run on, no tick: hold
    {1'b0, 2'd0, 16'h0000, 1'b1, 16'hFFFE, 1'b0, 1'b0, 4'd2}, // tick: decrement
    {1'b1, 2'd0, 16'h0002, 1'b1, 16'h0002, 1'b0, 1'b0, 4'd3}, // load beats tick
    {1'b0, 2'd0, 16'h0000, 1'b1, 16'h0001, 1'b0, 1'b0, 4'd2},
    {1'b0, 2'd0, 16'h0000, 1'b0, 16'h0001, 1'b0, 1'b0, 4'd2}, // idle hold
    {1'b0, 2'd0, 16'h0000, 1'b1, 16'h0000, 1'b0, 1'b0, 4'd2},
    {1'b0, 2'd0, 16'h0000, 1'b1, 16'hFFFF, 1'b1, 1'b0, 4'd4}, // wrap + set
    {1'b1, 2'd1, 16'h0003, 1'b0, 16'hFFFF, 1'b1, 1'b1, 4'd9}, // irq enable
    {1'b1, 2'd2, 16'h0000, 1'b0, 16'hFFFF, 1'b1, 1'b1, 4'd6}, // write 0: no clear
    {1'b0, 2'd0, 16'h0000, 1'b1, 16'hFFFE, 1'b1, 1'b1, 4'd6}, // sticky across tick
    {1'b1, 2'd1, 16'h0003, 1'b0, 16'hFFFE, 1'b1, 1'b1, 4'd6}, // ctrl write: no clear
    {1'b1, 2'd2, 16'h0001, 1'b0, 16'hFFFE, 1'b0, 1'b0, 4'd7}, // W1C
    {1'b1, 2'd0, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd3},
    {1'b1, 2'd2, 16'h0001, 1'b1, 16'hFFFF, 1'b1, 1'b1, 4'd8}, // set beats clear
    {1'b1, 2'd1, 16'h0001, 1'b0, 16'hFFFF, 1'b1, 1'b0, 4'd9}, // irq masked
    {1'b1, 2'd1, 16'h0000, 1'b0, 16'hFFFF, 1'b1, 1'b0, 4'd2}, // stop
    {1'b0, 2'd0, 16'h0000, 1'b1, 16'hFFFF, 1'b1, 1'b0, 4'd2}, // tick while stopped
    {1'b1, 2'd0, 16'h1234, 1'b0, 16'h1234, 1'b1, 1'b0, 4'd3}  // load while stopped
  };

  task automatic chk(input string req, input logic [15:0] c, input logic s, input logic i);
    total++;
    if (count_o !== c || status_o !== s || irq_o !== i) begin
      bad++;
      $display("FAIL %s: count=%h status=%b irq=%b expected count=%h status=%b irq=%b",
               req, count_o, status_o, irq_o, c, s, i);
    end
  endtask

  task automatic chk_reset(input string req);
    total++;
    if (count_o !== 16'hFFFF || run_o !== 1'b0 || ien_o !== 1'b0 ||
        status_o !== 1'b0 || irq_o !== 1'b0) begin
      bad++;
      $display("FAIL %s: count=%h run=%b ien=%b status=%b irq=%b expected FFFF 0 0 0 0",
               req, count_o, run_o, ien_o, status_o, irq_o);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 chk_reset("R1 held");
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk_reset("R1 released");
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      {wr_en_i, wr_addr_i, wr_data_i, tick_i} = VEC[k][41:22];
      @(posedge clk);
      #1 chk($sformatf("R%0d vec%0d", VEC[k][3:0], k), VEC[k][21:6], VEC[k][5], VEC[k][4]);
    end
    @(negedge clk);
    wr_en_i = 1'b0; tick_i = 1'b0;
    // R9 control readback: run from bit 0, ien from bit 1
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 2'd1; wr_data_i = 16'h0002;
    @(posedge clk);
    #1 total++;
    if (run_o !== 1'b0 || ien_o !== 1'b1 || irq_o !== 1'b1) begin
      bad++;
      $display("FAIL R9 ctrl: run=%b ien=%b irq=%b expected 0 1 1", run_o, ien_o, irq_o);
    end
    @(negedge clk);
    wr_en_i = 1'b0;
    // R1: asynchronous reset in the middle of operation
    #1 rst_n = 1'b0;
    #1 chk_reset("R1 async");
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk_reset("R1 after re-release");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 5000);
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule